// File: doc/BRIEF.md
# Compare-and-Branch Condition Unit

This unit resolves jump-class instructions for a 64-bit register machine that has no flag register. Each instruction carries its own comparison. The unit takes the opcode, the destination operand, the source register value, a 32-bit immediate, a signed 16-bit displacement and the current instruction index. It decides whether the branch is taken and produces the index of the next instruction. The condition selects the next instruction directly, and no intermediate state is kept.

Every condition can compare against either a second register or the sign-extended immediate. The conditions are equality, inequality, a bit-test, unsigned ordering and two's-complement ordering. The unit also provides an unconditional jump. Opcodes outside the accepted set raise an illegal flag and never redirect the flow. All results are registered, so they appear one clock after the inputs are sampled.

Top module: `jcu_top`

## Requirements
- R1: While reset is asserted, and until the first clock edge after reset is released, taken_o, illegal_o and next_pc_o are all 0. After that, the outputs at each clock edge reflect the inputs sampled at that edge.
- R2: Opcode 0x05 is always taken and never illegal, whatever the operand values are.
- R3: For conditional opcodes, bit 3 of the opcode selects the second operand. When bit 3 is 1, the second operand is src_i. When bit 3 is 0, it is imm_i sign-extended to 64 bits, so that imm 0xFFFFFFFF compares as all ones.
- R4: High nibble 0x1 is taken on equality and high nibble 0x5 on inequality. High nibble 0x4 is taken when the AND of the operands is nonzero. In each case the low nibble is 0x5 or 0xD.
- R5: The high nibbles 0x2, 0x3, 0xA and 0xB select unsigned greater, greater-or-equal, less and less-or-equal on 64-bit magnitudes.
- R6: The high nibbles 0x6, 0x7, 0xC and 0xD select signed greater, greater-or-equal, less and less-or-equal in 64-bit two's complement.
- R7: next_pc_o is pc_i + 1 + sign-extended off_i when the branch is taken, and pc_i + 1 when it is not, both modulo 2^PC_W.
- R8: Any opcode not named in R2, R4, R5 or R6 (for example 0x0D, 0x85, 0x07) sets illegal_o, clears taken_o and gives next_pc_o = pc_i + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 8 | Instruction opcode |
| dst_i | input | 64 | First comparison operand |
| src_i | input | 64 | Source register value |
| imm_i | input | 32 | Immediate field |
| off_i | input | 16 | Signed branch displacement |
| pc_i | input | PC_W (32) | Current instruction index |
| taken_o | output | 1 | Branch decision |
| next_pc_o | output | PC_W (32) | Index of the next instruction |
| illegal_o | output | 1 | Opcode not accepted |

## Verification
Two functions can fall in the same cycle. The first is illegal-opcode rejection, which arrives together with a comparison that would be true on the operands given. The bench provokes this with opcode 0x0D and equal operands, and with random bytes mixed into the stream. It judges the result by requiring not-taken and a sequential next index. The second pairing is a taken decision together with an index sum that wraps past 2^PC_W. The bench forces this with an index near all ones and with a negative displacement near zero, and it compares the result against a modular model.

// File: rtl/jcu_pkg.sv
package jcu_pkg;
   localparam int OP_W = 8;

   typedef enum logic [3:0] {
      C_ALWAYS, C_EQ, C_NE, C_SET,
      C_UGT, C_UGE, C_ULT, C_ULE,
      C_SGT, C_SGE, C_SLT, C_SLE,
      C_NEVER
   } cond_e;
endpackage

// File: rtl/jcu_decode.sv
module jcu_decode
   import jcu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output cond_e           cond,
   output logic            use_reg,
   output logic            bad
);
   logic is_jmp;

   always_comb begin
      is_jmp  = (op[2:0] == 3'b101);
      use_reg = op[3];
      cond    = C_NEVER;
      if (is_jmp) begin
         unique case (op[7:4])
            4'h0: cond = op[3] ? C_NEVER : C_ALWAYS;
            4'h1: cond = C_EQ;
            4'h2: cond = C_UGT;
            4'h3: cond = C_UGE;
            4'h4: cond = C_SET;
            4'h5: cond = C_NE;
            4'h6: cond = C_SGT;
            4'h7: cond = C_SGE;
            4'hA: cond = C_ULT;
            4'hB: cond = C_ULE;
            4'hC: cond = C_SLT;
            4'hD: cond = C_SLE;
            default: cond = C_NEVER;
         endcase
      end
      bad = (cond == C_NEVER);
   end
endmodule

// File: rtl/jcu_operand.sv
module jcu_operand #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32
) (
   input  logic [DATA_W-1:0] src,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_reg,
   output logic [DATA_W-1:0] rhs
);
   logic [DATA_W-1:0] imm_ext;

   generate
      if (IMM_W > DATA_W) begin : g_bad
         $error("jcu_operand: IMM_W wider than DATA_W");
      end else if (IMM_W == DATA_W) begin : g_same
         assign imm_ext = imm;
      end else begin : g_ext
         assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
      end
   endgenerate

   assign rhs = use_reg ? src : imm_ext;
endmodule

// File: rtl/jcu_compare.sv
module jcu_compare
   import jcu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  cond_e             cond,
   output logic              hit
);
   logic eq, ult, slt, any;

   always_comb begin
      eq  = (lhs == rhs);
      ult = (lhs < rhs);
      slt = ($signed(lhs) < $signed(rhs));
      any = |(lhs & rhs);
      unique case (cond)
         C_ALWAYS: hit = 1'b1;
         C_EQ:     hit = eq;
         C_NE:     hit = !eq;
         C_SET:    hit = any;
         C_UGT:    hit = !ult && !eq;
         C_UGE:    hit = !ult;
         C_ULT:    hit = ult;
         C_ULE:    hit = ult || eq;
         C_SGT:    hit = !slt && !eq;
         C_SGE:    hit = !slt;
         C_SLT:    hit = slt;
         C_SLE:    hit = slt || eq;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/jcu_target.sv
module jcu_target #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   input  logic             take,
   output logic [PC_W-1:0]  nxt
);
   localparam int PAD = PC_W - OFF_W;

   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] seq;

   generate
      if (PC_W < OFF_W) begin : g_bad
         $error("jcu_target: PC_W narrower than OFF_W");
      end else if (PAD == 0) begin : g_same
         assign off_ext = off;
      end else begin : g_ext
         assign off_ext = {{PAD{off[OFF_W-1]}}, off};
      end
   endgenerate

   assign seq = pc + PC_W'(1);
   assign nxt = take ? seq + off_ext : seq;
endmodule

// File: rtl/jcu_top.sv
module jcu_top
   import jcu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32,
   parameter int OFF_W  = 16,
   parameter int PC_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        op_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [PC_W-1:0]   pc_i,
   output logic              taken_o,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              illegal_o
);
   generate
      if (DATA_W < 2) begin : g_chk_data
         $error("jcu_top: DATA_W too small");
      end
   endgenerate

   cond_e             cond;
   logic              use_reg, bad, hit;
   logic [DATA_W-1:0] rhs;
   logic [PC_W-1:0]   nxt;
   logic              q_live;

   jcu_decode u_dec (.op(op_i), .cond(cond), .use_reg(use_reg), .bad(bad));

   jcu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opd (
      .src(src_i), .imm(imm_i), .use_reg(use_reg), .rhs(rhs));

   jcu_compare #(.DATA_W(DATA_W)) u_cmp (
      .lhs(dst_i), .rhs(rhs), .cond(cond), .hit(hit));

   jcu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
      .pc(pc_i), .off(off_i), .take(hit), .nxt(nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken_o   <= 1'b0;
         illegal_o <= 1'b0;
         next_pc_o <= '0;
         q_live    <= 1'b0;
      end else begin
         taken_o   <= hit;
         illegal_o <= bad;
         next_pc_o <= nxt;
         q_live    <= 1'b1;
      end
   end

   // R1: outputs stay cleared until a sampled instruction reaches them
   a_r1_reset_clear: assert property (@(posedge clk)
      !q_live |-> (!taken_o && !illegal_o && next_pc_o == '0));

   // R2: unconditional jump always taken
   a_r2_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && $past(op_i) == 8'h05) |-> (taken_o && !illegal_o));

   // R4: bit-test with register source not taken on disjoint bits
   a_r4_set_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && $past(op_i) == 8'h4d && ($past(dst_i) & $past(src_i)) == '0)
      |-> !taken_o);

   // R7: sequential index when not taken
   a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && !taken_o) |-> next_pc_o == $past(pc_i) + PC_W'(1));

   // R7: displaced index when taken
   a_r7_displaced: assert property (@(posedge clk) disable iff (!rst_n)
      (q_live && taken_o) |->
      next_pc_o == $past(pc_i) + PC_W'(1) + PC_W'($signed($past(off_i))));

   // R8: illegal opcode never redirects
   a_r8_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !taken_o);
endmodule

// File: tb/sim_jcu_top.sv
module sim_jcu_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  op_i = '0;
   logic [63:0] dst_i = '0, src_i = '0;
   logic [31:0] imm_i = '0;
   logic [15:0] off_i = '0;
   logic [31:0] pc_i = '0;
   logic        taken_o, illegal_o;
   logic [31:0] next_pc_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jcu_top u0 (.clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i),
      .src_i(src_i), .imm_i(imm_i), .off_i(off_i), .pc_i(pc_i),
      .taken_o(taken_o), .next_pc_o(next_pc_o), .illegal_o(illegal_o));

   function automatic string tag_of(input logic [7:0] op);
      if (op == 8'h05) return "R2";
      if (op[2:0] != 3'b101) return "R8";
      case (op[7:4])
         4'h1, 4'h4, 4'h5:       return "R4";
         4'h2, 4'h3, 4'hA, 4'hB: return "R5";
         4'h6, 4'h7, 4'hC, 4'hD: return "R6";
         default:                return "R8";
      endcase
   endfunction

   function automatic bit ref_legal(input logic [7:0] op);
      if (op == 8'h05) return 1'b1;
      if (op[2:0] != 3'b101) return 1'b0;
      case (op[7:4])
         4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
         4'hA, 4'hB, 4'hC, 4'hD: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit ref_take(input logic [7:0] op, input logic [63:0] a,
                                   input logic [63:0] s, input logic [31:0] im);
      logic [63:0] b;
      if (!ref_legal(op)) return 1'b0;
      if (op == 8'h05) return 1'b1;
      b = op[3] ? s : {{32{im[31]}}, im};
      case (op[7:4])
         4'h1: return a == b;
         4'h5: return a != b;
         4'h4: return (a & b) != 0;
         4'h2: return a > b;
         4'h3: return a >= b;
         4'hA: return a < b;
         4'hB: return a <= b;
         4'h6: return $signed(a) > $signed(b);
         4'h7: return $signed(a) >= $signed(b);
         4'hC: return $signed(a) < $signed(b);
         4'hD: return $signed(a) <= $signed(b);
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [7:0] op, input logic [63:0] a,
                      input logic [63:0] s, input logic [31:0] im,
                      input logic [15:0] off, input logic [31:0] pc);
      bit          t, il;
      logic [31:0] nx;
      @(negedge clk);
      op_i = op; dst_i = a; src_i = s; imm_i = im; off_i = off; pc_i = pc;
      t  = ref_take(op, a, s, im);
      il = !ref_legal(op);
      nx = t ? pc + 32'd1 + {{16{off[15]}}, off} : pc + 32'd1;
      @(posedge clk); #1;
      check(tag_of(op), "taken", 64'(taken_o), 64'(t));
      check(il ? "R8" : tag_of(op), "illegal", 64'(illegal_o), 64'(il));
      check("R7", "next index", 64'(next_pc_o), 64'(nx));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] hi [12] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50,
                              8'h60, 8'h70, 8'hA0, 8'hB0, 8'hC0, 8'hD0};
      void'($urandom(32'd1234));
      op_i = 8'h05; pc_i = 32'h55;
      repeat (3) @(posedge clk);
      #1;
      // R1: held in reset
      check("R1", "taken in reset", 64'(taken_o), 64'd0);
      check("R1", "illegal in reset", 64'(illegal_o), 64'd0);
      check("R1", "index in reset", 64'(next_pc_o), 64'd0);
      @(negedge clk); rst_n = 1'b1;

      // R2 with backward displacement, R7 wrap
      run(8'h05, 0, 0, 0, 16'hFFF0, 32'd3);
      run(8'h05, 0, 0, 0, 16'd4, 32'hFFFF_FFFE);
      // R3: imm all ones equals all-ones register value
      run(8'h15, '1, 0, 32'hFFFF_FFFF, 16'd7, 32'd100);
      run(8'h1d, '1, 64'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd7, 32'd100);
      // R4 bit-test
      run(8'h4d, 64'hF0, 64'h0F, 0, 16'd2, 32'd10);
      run(8'h45, 64'h8000_0000_0000_0000, 0, 32'h8000_0000, 16'd2, 32'd10);
      // R5 / R6 sign boundary
      run(8'h2d, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd9, 32'd20);
      run(8'h6d, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd9, 32'd20);
      run(8'hBd, 64'd5, 64'd5, 0, 16'd1, 32'd20);
      run(8'hCd, 64'd5, 64'd5, 0, 16'd1, 32'd20);
      // R8 illegal with otherwise-true comparison
      run(8'h0d, 64'd1, 64'd1, 0, 16'd5, 32'd30);
      run(8'h85, 0, 0, 0, 16'd5, 32'd30);
      run(8'h07, 0, 0, 0, 16'd5, 32'd30);

      for (int i = 0; i < 3000; i++) begin
         logic [7:0]  op;
         logic [63:0] a, s;
         logic [31:0] im;
         int          m;
         if ($urandom_range(9) == 0) op = 8'($urandom);
         else op = hi[$urandom_range(11)] | ($urandom_range(1) ? 8'h0d : 8'h05);
         a  = {$urandom, $urandom};
         s  = {$urandom, $urandom};
         im = $urandom;
         m  = $urandom_range(3);
         if (m == 0) begin s = a; im = a[31:0]; end
         else if (m == 1) begin
            a = {$urandom_range(1) ? 32'h8000_0000 : 32'h7FFF_FFFF, 32'($urandom_range(3))};
            s = {$urandom_range(1) ? 32'h8000_0000 : 32'h7FFF_FFFF, 32'($urandom_range(3))};
         end
         run(op, a, s, im, 16'($urandom), $urandom);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule